// File: doc/BRIEF.md
# Crossbar Slave Port Arbiter

This block is the slave side of one port in a multi-master AHB-style crossbar. Eight master ports present requests together with their address, control and write-data bundles. The block picks which master owns the slave bus, routes that master's signals to the slave, and steers the slave's ready and response back to the right master. Ownership is pipelined. The master granted at a ready edge drives the next address phase. The previous address owner moves into its data phase, and the write data follows that data-phase owner.

Every path to the slave is an AND-OR selector driven by a one-hot owner vector. When no master owns the port, the slave sees all-zero address, control and write data, which is a quiet park state. A halt input stops new grants and drains the pipe. The block then raises an acknowledge once both pipeline stages are empty.

The port also qualifies the transfer type at control bits [1:0] (00 IDLE, 10 NONSEQ, 11 SEQ). It forces IDLE while parked. On the first address phase after a change of owner, it turns an active type into NONSEQ.

Top module: `xbar_slave_port`

## Requirements
- R1: At most one master owns the address phase (`own_addr` is one-hot or zero). A grant goes only to a master whose request was high at the deciding ready edge. With no requests, the port parks with `own_addr` zero.
- R2: If any requesting master has its high-priority bit set, the grant goes to one of those high-priority requesters.
- R3: Within one priority level, the grant goes to the first requester found searching upward, with wrap-around, from the index after the last granted master. After reset, master 0 is searched first.
- R4: Ownership changes only at a clock edge where `slv_hready` is high. While it is low, `own_addr` and `own_data` hold.
- R5: At each ready edge `own_data` takes the previous `own_addr`. `s_addr` and `s_ctrl` come from the address owner. `s_wdata` comes from the data owner.
- R6: With no address owner, `s_addr` and `s_ctrl` are zero, so the transfer type is IDLE (00). With no data owner, `s_wdata` is zero.
- R7: On the first address phase after ownership passes to a new master, a transfer type with bit 1 set (10 or 11) reaches the slave as NONSEQ (10). Later address phases of the same owner pass the type unchanged.
- R8: While `halt_req` is high, no master is granted. `halted` rises at the first ready edge at which the address stage is already empty, so both stages are then empty. It falls at the first ready edge after `halt_req` drops.
- R9: A master that owns either stage sees `slv_hready` on its `m_hready` bit. A requesting master that owns neither stage sees 0. A master with no request and no ownership sees 1.
- R10: `slv_hresp` reaches only the data-phase owner's `m_hresp` bit. All other bits are 0.
- R11: After reset, no master owns either stage, `halted` is low, and master 0 is first in the round-robin search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | NM | Per-master transfer request |
| m_hipri | input | NM | Per-master high-priority flag |
| m_addr | input | NM*AW | Packed master addresses, master i at [i*AW +: AW] |
| m_ctrl | input | NM*CW | Packed master control, transfer type in bits [1:0] of each slice |
| m_wdata | input | NM*DW | Packed master write data |
| halt_req | input | 1 | Request to park the port |
| slv_hready | input | 1 | Slave ready |
| slv_hresp | input | 1 | Slave error response |
| s_addr | output | AW | Address to slave |
| s_ctrl | output | CW | Control to slave with qualified transfer type |
| s_wdata | output | DW | Write data to slave |
| m_hready | output | NM | Per-master ready |
| m_hresp | output | NM | Per-master response |
| own_addr | output | NM | One-hot address-phase owner |
| own_data | output | NM | One-hot data-phase owner |
| halted | output | 1 | Port parked by halt |

## Verification
Round-robin wrap is a key target. After the highest index wins, the search must restart at master 0. A design that searches from a fixed origin or from the current owner would keep granting the same master.

A high-priority bit on a master that is not requesting must not disturb the normal rotation. A low `slv_hready` must freeze both owner stages. A design that re-arbitrates on every edge would switch masters mid-wait.

The pipeline split is checked by comparing `s_wdata` with the data owner while a different master owns the address. The halt drain is checked by confirming that `halted` waits for the data stage to empty and that grants resume afterwards. The NONSEQ forcing is checked to apply on exactly one address phase, so a design that never clears it would corrupt SEQ transfers.

// File: rtl/xbar_slave_port.sv
module xbar_slave_port #(
  parameter int NM = 8,
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int DW = 32,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_req,
  input  logic [NM-1:0]    m_hipri,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NM*CW-1:0] m_ctrl,
  input  logic [NM*DW-1:0] m_wdata,
  input  logic             halt_req,
  input  logic             slv_hready,
  input  logic             slv_hresp,
  output logic [AW-1:0]    s_addr,
  output logic [CW-1:0]    s_ctrl,
  output logic [DW-1:0]    s_wdata,
  output logic [NM-1:0]    m_hready,
  output logic [NM-1:0]    m_hresp,
  output logic [NM-1:0]    own_addr,
  output logic [NM-1:0]    own_data,
  output logic             halted
);
  logic [NM-1:0] cand, grant;
  logic [IW-1:0] last, win;
  logic          found, nseq_pend;
  logic [CW-1:0] ctrl_raw;

  always_comb begin
    cand  = ((m_req & m_hipri) != '0) ? (m_req & m_hipri) : m_req;
    win   = last;
    found = 1'b0;
    for (int k = NM; k >= 1; k--) begin
      if (cand[(int'(last) + k) % NM]) begin
        win   = IW'((int'(last) + k) % NM);
        found = 1'b1;
      end
    end
    grant = (found && !halt_req) ? (NM'(1) << win) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr  <= '0;
      own_data  <= '0;
      last      <= IW'(NM - 1);
      nseq_pend <= 1'b0;
      halted    <= 1'b0;
    end else if (slv_hready) begin
      own_addr  <= grant;
      own_data  <= own_addr;
      if (grant != '0) last <= win;
      nseq_pend <= (grant != '0) && (grant != own_addr);
      halted    <= halt_req && (own_addr == '0);
    end
  end

  always_comb begin
    s_addr   = '0;
    ctrl_raw = '0;
    s_wdata  = '0;
    for (int i = 0; i < NM; i++) begin
      s_addr   = s_addr   | (m_addr[i*AW +: AW]  & {AW{own_addr[i]}});
      ctrl_raw = ctrl_raw | (m_ctrl[i*CW +: CW]  & {CW{own_addr[i]}});
      s_wdata  = s_wdata  | (m_wdata[i*DW +: DW] & {DW{own_data[i]}});
    end
    s_ctrl = ctrl_raw;
    if (nseq_pend && ctrl_raw[1]) s_ctrl[1:0] = 2'b10;
    if (own_addr == '0)           s_ctrl[1:0] = 2'b00;
  end

  assign m_hready = ((own_addr | own_data) & {NM{slv_hready}}) | (~(own_addr | own_data) & ~m_req);
  assign m_hresp  = own_data & {NM{slv_hresp}};
endmodule

module xbar_slave_port_chk #(
  parameter int NM = 8,
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] m_req,
  input logic [NM-1:0] m_hipri,
  input logic          halt_req,
  input logic          slv_hready,
  input logic          slv_hresp,
  input logic [AW-1:0] s_addr,
  input logic [CW-1:0] s_ctrl,
  input logic [NM-1:0] m_hready,
  input logic [NM-1:0] m_hresp,
  input logic [NM-1:0] own_addr,
  input logic [NM-1:0] own_data,
  input logic          halted
);
  // R1
  onehot_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_addr) && $onehot0(own_data));
  // R1
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_hready |=> (own_addr == '0) || ((own_addr & $past(m_req)) != '0));
  // R2
  hipri_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_hready && !halt_req && ((m_req & m_hipri) != '0)) |=> ((own_addr & $past(m_req & m_hipri)) != '0));
  // R4
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_hready |=> $stable(own_addr) && $stable(own_data));
  // R5
  data_follows_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_hready |=> own_data == $past(own_addr));
  // R6
  park_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_addr == '0) |-> (s_addr == '0) && (s_ctrl == '0));
  // R8
  halt_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_hready && halt_req) |=> own_addr == '0);
  // R8
  halted_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (own_addr == '0) && (own_data == '0));
  // R9
  waiting_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hready & m_req & ~own_addr & ~own_data) == '0);
  // R10
  resp_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hresp & ~own_data) == '0);
endmodule

bind xbar_slave_port xbar_slave_port_chk #(.NM(NM), .AW(AW), .CW(CW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_hipri(m_hipri), .halt_req(halt_req),
  .slv_hready(slv_hready), .slv_hresp(slv_hresp), .s_addr(s_addr), .s_ctrl(s_ctrl),
  .m_hready(m_hready), .m_hresp(m_hresp), .own_addr(own_addr), .own_data(own_data),
  .halted(halted)
);

// File: tb/xbar_slave_port_tb.sv
module xbar_slave_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 8, AW = 32, CW = 4, DW = 32;

  // {req, hipri, halt, ready, exp_own_addr, exp_own_data}
  localparam bit [33:0] VEC [0:11] = '{
    {8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00},
    {8'h05, 8'h00, 1'b0, 1'b1, 8'h01, 8'h00},
    {8'h05, 8'h00, 1'b0, 1'b1, 8'h04, 8'h01},
    {8'h05, 8'h00, 1'b0, 1'b1, 8'h01, 8'h04},
    {8'h05, 8'h80, 1'b0, 1'b1, 8'h04, 8'h01},
    {8'h85, 8'h80, 1'b0, 1'b1, 8'h80, 8'h04},
    {8'h05, 8'h00, 1'b0, 1'b0, 8'h80, 8'h04},
    {8'h05, 8'h00, 1'b0, 1'b1, 8'h01, 8'h80},
    {8'h05, 8'h00, 1'b1, 1'b1, 8'h00, 8'h01},
    {8'h05, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00},
    {8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00},
    {8'h06, 8'h06, 1'b0, 1'b1, 8'h02, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic [NM-1:0] m_req = '0, m_hipri = '0;
  logic [NM*AW-1:0] m_addr;
  logic [NM*CW-1:0] m_ctrl;
  logic [NM*DW-1:0] m_wdata;
  logic halt_req = 0, slv_hready = 1, slv_hresp = 0;
  logic [AW-1:0] s_addr;
  logic [CW-1:0] s_ctrl;
  logic [DW-1:0] s_wdata;
  logic [NM-1:0] m_hready, m_hresp, own_addr, own_data;
  logic halted;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbar_slave_port #(.NM(NM), .AW(AW), .CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_hipri(m_hipri), .m_addr(m_addr),
    .m_ctrl(m_ctrl), .m_wdata(m_wdata), .halt_req(halt_req), .slv_hready(slv_hready),
    .slv_hresp(slv_hresp), .s_addr(s_addr), .s_ctrl(s_ctrl), .s_wdata(s_wdata),
    .m_hready(m_hready), .m_hresp(m_hresp), .own_addr(own_addr), .own_data(own_data),
    .halted(halted));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    m_req = '0; m_hipri = '0; halt_req = 0; slv_hready = 1; slv_hresp = 0;
    rst_n = 0;
    step();
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NM; i++) begin
      m_addr[i*AW +: AW]  = 32'hA000_0000 | (i << 8);
      m_wdata[i*DW +: DW] = 32'h5000_0000 | (i << 4) | 32'h3;
      m_ctrl[i*CW +: CW]  = 4'b0111;
    end
    @(negedge clk);
    do_reset();

    // R11 reset state, R6 parked outputs zero
    chk("R11 own_addr", own_addr, 0);
    chk("R11 own_data", own_data, 0);
    chk("R11 halted", halted, 0);
    chk("R9 idle hready", m_hready, 8'hFF);
    chk("R6 s_addr parked", s_addr, 0);
    chk("R6 s_ctrl parked", s_ctrl, 0);
    chk("R6 s_wdata parked", s_wdata, 0);

    // R1 R2 R3 R4 R5 R8 vector walk
    for (int v = 0; v < 12; v++) begin
      {m_req, m_hipri, halt_req, slv_hready} = VEC[v][33:16];
      step();
      chk($sformatf("R1/R2/R3/R4 vec%0d own_addr", v), own_addr, VEC[v][15:8]);
      chk($sformatf("R5/R8 vec%0d own_data", v), own_data, VEC[v][7:0]);
    end

    do_reset();
    m_req = 8'h08;
    step();
    chk("R1 grant m3", own_addr, 8'h08);
    chk("R5 s_addr m3", s_addr, 32'hA000_0300);
    chk("R7 forced NONSEQ", s_ctrl, 4'b0110);
    chk("R9 owner hready", m_hready[3], 1);
    step();
    chk("R7 SEQ passes", s_ctrl, 4'b0111);
    chk("R5 s_wdata m3", s_wdata, 32'h5000_0033);

    m_req = 8'h28;
    step();
    chk("R3 rotate to m5", own_addr, 8'h20);
    chk("R5 addr from m5", s_addr, 32'hA000_0500);
    chk("R5 wdata from m3", s_wdata, 32'h5000_0033);
    chk("R7 NONSEQ on m5", s_ctrl, 4'b0110);

    m_req = 8'h68;
    #1;
    chk("R9 waiting m6 hready", m_hready[6], 0);
    chk("R9 idle m0 hready", m_hready[0], 1);
    slv_hresp = 1;
    #1;
    chk("R10 hresp to data owner", m_hresp, 8'h08);
    slv_hready = 0;
    #1;
    chk("R9 owners see wait", m_hready & 8'h28, 8'h00);
    step();
    chk("R4 hold addr", own_addr, 8'h20);
    chk("R4 hold data", own_data, 8'h08);
    slv_hready = 1; slv_hresp = 0;

    halt_req = 1;
    step();
    chk("R8 no grant in halt", own_addr, 0);
    chk("R8 not yet halted", halted, 0);
    chk("R6 s_addr zero in halt", s_addr, 0);
    step();
    chk("R8 halted", halted, 1);
    chk("R8 data drained", own_data, 0);
    step();
    chk("R8 stays parked", own_addr, 0);
    halt_req = 0;
    step();
    chk("R8 halted released", halted, 0);
    chk("R3 resume m6", own_addr, 8'h40);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule